// File: doc/BRIEF.md
# CAN Controller Mode and Status Logic

This block keeps the operating mode of a CAN controller (sleep, initialization or normal) and presents an 8-bit status word built from that mode and from the controller's activity. Software asks for a mode by holding two request inputs. The block confirms each mode change through acknowledge flags, mirrors receive and transmit activity while in normal mode, and latches a wake-up flag and an error flag. Software clears the latched flags by writing ones through a clear port. It raises a status-change interrupt when a latched flag is set and that flag's enable is on.

Leaving initialization is gated by bus synchronization. After the initialization request drops, the block counts consecutive recessive bits on the sampled RX stream, counting only on bit-strobe cycles. A dominant bit restarts the count. The block enters normal mode only when the count reaches the configured run length, which is 11 by default.

Top module: `canModeStatus`

## Requirements
- R1: After reset the status word reads 0x02 (only the sleep acknowledge set) and the status-change interrupt is low.
- R2: Status word layout: bit 0 init acknowledge, bit 1 sleep acknowledge, bit 2 error flag, bit 3 wake-up flag, bit 4 transmitter active, bit 5 receiver active, bits 7:6 always read 0.
- R3: When the init request is high at a clock edge, the block is in initialization mode after that edge, with init acknowledge 1 and sleep acknowledge 0. The init request takes priority over the sleep request.
- R4: Init acknowledge clears only after the init request and the sleep request are both low and 11 consecutive recessive (1) bits have been seen on strobe cycles. It clears at the edge of the 11th such strobe. A dominant (0) bit on a strobe restarts the count. Cycles without a strobe neither count nor restart.
- R5: With the init request low, a high sleep request moves the block from normal or initialization mode into sleep mode (sleep acknowledge 1, init acknowledge 0) at the next edge. In sleep mode, a low sleep request moves the block into normal mode at the next edge and clears sleep acknowledge.
- R6: An SOF-detected pulse while in sleep mode sets the wake-up flag. The same pulse in any other mode has no effect.
- R7: The error flag sets on a 0-to-1 transition of any error input bit whose enable bit is set. Transitions on disabled bits, and error bits held high, do not set it.
- R8: Writing the clear port with bit 3 or bit 2 set clears the wake-up or error flag. Zero bits, and all other bit positions, have no effect.
- R9: When a set event and a clear of the same flag occur in the same cycle, the flag stays set.
- R10: The status-change interrupt equals (wake-up flag AND wake interrupt enable) OR (error flag AND error interrupt enable).
- R11: Receiver active and transmitter active follow the busy inputs with one cycle of latency in normal mode, and read 0 in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| initReq | input | 1 | Software initialization request (level) |
| sleepReq | input | 1 | Software sleep request (level) |
| rxBit | input | 1 | Sampled RX bit, 1 = recessive |
| bitStrobe | input | 1 | Marks the cycle in which rxBit holds a new bit |
| sofSeen | input | 1 | Start-of-frame detected pulse |
| rxBusy | input | 1 | Protocol engine is receiving |
| txBusy | input | 1 | Protocol engine is transmitting |
| errFlags | input | ERR_W | Error status bits from the error logic |
| errEnables | input | ERR_W | Per-bit error interrupt enables |
| wakeIntEn | input | 1 | Wake-up interrupt enable |
| errIntEn | input | 1 | Error interrupt enable |
| clrWrite | input | 1 | Write strobe of the clear port |
| clrData | input | 8 | Write-one-to-clear data |
| rdData | output | 8 | Status word |
| statusIrq | output | 1 | Status-change interrupt |

## Verification
The synchronization gate is driven with recessive runs of every length from 1 to 10, each broken by a dominant strobe, and then with a full run of 11. Non-strobe dominant cycles are placed inside the runs. This separates a counter that restarts on dominant bits from one that accumulates, and a counter that counts on strobes from one that counts every cycle. The error flag is swept over every combination of error bits and enables, and then held high, which separates edge detection from level detection and enabled bits from disabled ones. The mode transitions are walked through every path between sleep, initialization and normal, including simultaneous requests, and same-cycle set/clear pairs are applied to both latched flags.

// File: rtl/canModePkg.sv
package canModePkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_NORMAL = 2'd2
  } canMode_e;

  // Strobes from the mode control to the status datapath
  typedef struct packed {
    logic setInitAck;
    logic clrInitAck;
    logic setSleepAck;
    logic clrSleepAck;
    logic inSleep;
    logic inNormal;
  } modeStrobes_t;

endpackage

// File: rtl/canModeCtrl.sv
module canModeCtrl
  import canModePkg::*;
#(
  parameter int SYNC_BITS = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         initReq,
  input  logic         sleepReq,
  input  logic         rxBit,
  input  logic         bitStrobe,
  output modeStrobes_t strb
);

  localparam int CNT_W = $clog2(SYNC_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SYNC_BITS - 1);

  canMode_e mode, nextMode;
  logic [CNT_W-1:0] recCnt;
  logic syncDone;
  logic counting;

  assign counting = (mode == MODE_INIT) && !initReq && !sleepReq;
  assign syncDone = counting && bitStrobe && rxBit && (recCnt == LAST_CNT);

  always_comb begin
    nextMode = mode;
    if (initReq) begin
      nextMode = MODE_INIT;
    end else if (sleepReq) begin
      nextMode = MODE_SLEEP;
    end else begin
      case (mode)
        MODE_SLEEP:  nextMode = MODE_NORMAL;
        MODE_INIT:   nextMode = syncDone ? MODE_NORMAL : MODE_INIT;
        MODE_NORMAL: nextMode = MODE_NORMAL;
        default:     nextMode = MODE_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MODE_SLEEP;
    end else begin
      mode <= nextMode;
    end
  end

  // Consecutive recessive bit counter, advanced on strobes only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (!counting) begin
      recCnt <= '0;
    end else if (bitStrobe) begin
      if (!rxBit || syncDone) begin
        recCnt <= '0;
      end else begin
        recCnt <= recCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.setInitAck  = (mode != MODE_INIT) && (nextMode == MODE_INIT);
    strb.clrInitAck  = (mode == MODE_INIT) && (nextMode != MODE_INIT);
    strb.setSleepAck = (mode != MODE_SLEEP) && (nextMode == MODE_SLEEP);
    strb.clrSleepAck = (mode == MODE_SLEEP) && (nextMode != MODE_SLEEP);
    strb.inSleep     = (mode == MODE_SLEEP);
    strb.inNormal    = (mode == MODE_NORMAL);
  end

  // R3: an init request always lands in initialization mode
  assert_init_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (mode == MODE_INIT))
    else $error("init request did not enter init mode");

  // R4: a dominant strobe never releases initialization
  assert_dominant_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_INIT) && bitStrobe && !rxBit) |=> (mode == MODE_INIT))
    else $error("left init on a dominant bit");

  // R4: counter stays below the run length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    recCnt < CNT_W'(SYNC_BITS))
    else $error("recessive counter overran");

  // R5: sleep request without init request lands in sleep mode
  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && !initReq) |=> (mode == MODE_SLEEP))
    else $error("sleep request not honoured");

endmodule

// File: rtl/canStatusPath.sv
module canStatusPath
  import canModePkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  modeStrobes_t     strb,
  input  logic             sofSeen,
  input  logic             rxBusy,
  input  logic             txBusy,
  input  logic [ERR_W-1:0] errFlags,
  input  logic [ERR_W-1:0] errEnables,
  input  logic             wakeIntEn,
  input  logic             errIntEn,
  input  logic             clrWrite,
  input  logic [7:0]       clrData,
  output logic [7:0]       statusReg,
  output logic             statusIrq
);

  localparam int WAKE_POS = 3;
  localparam int ERR_POS  = 2;

  logic initAck, sleepAck, wakeFlag, errFlag, rxAct, txAct;
  logic [ERR_W-1:0] errPrev;
  logic wakeSet, errSet, wakeClr, errClr;

  assign wakeSet = sofSeen && strb.inSleep;
  assign errSet  = |(errFlags & ~errPrev & errEnables);
  assign wakeClr = clrWrite && clrData[WAKE_POS];
  assign errClr  = clrWrite && clrData[ERR_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initAck  <= 1'b0;
      sleepAck <= 1'b1;
    end else begin
      if (strb.setInitAck) initAck <= 1'b1;
      else if (strb.clrInitAck) initAck <= 1'b0;
      if (strb.setSleepAck) sleepAck <= 1'b1;
      else if (strb.clrSleepAck) sleepAck <= 1'b0;
    end
  end

  // Latched flags: hardware set wins over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlag <= 1'b0;
      errFlag  <= 1'b0;
      errPrev  <= '0;
    end else begin
      errPrev <= errFlags;
      if (wakeSet) wakeFlag <= 1'b1;
      else if (wakeClr) wakeFlag <= 1'b0;
      if (errSet) errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAct <= 1'b0;
      txAct <= 1'b0;
    end else begin
      rxAct <= rxBusy && strb.inNormal;
      txAct <= txBusy && strb.inNormal;
    end
  end

  assign statusReg = {2'b00, rxAct, txAct, wakeFlag, errFlag, sleepAck, initAck};
  assign statusIrq = (wakeFlag && wakeIntEn) || (errFlag && errIntEn);

  // R3 / R5: acknowledges are never both set
  assert_ack_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(initAck && sleepAck))
    else $error("both acknowledges set");

  // R6: SOF while asleep sets the wake-up flag
  assert_wake_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sofSeen && strb.inSleep) |=> wakeFlag)
    else $error("wake-up flag missed");

  // R8: a clear with no competing set empties the wake-up flag
  assert_wake_clr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && clrData[WAKE_POS] && !sofSeen) |=> !wakeFlag)
    else $error("wake-up flag not cleared");

  // R11: activity bits read 0 after a non-normal cycle
  assert_act_mode_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inNormal |=> (!rxAct && !txAct))
    else $error("activity outside normal mode");

endmodule

// File: rtl/canModeStatus.sv
module canModeStatus
  import canModePkg::*;
#(
  parameter int SYNC_BITS = 11,
  parameter int ERR_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initReq,
  input  logic             sleepReq,
  input  logic             rxBit,
  input  logic             bitStrobe,
  input  logic             sofSeen,
  input  logic             rxBusy,
  input  logic             txBusy,
  input  logic [ERR_W-1:0] errFlags,
  input  logic [ERR_W-1:0] errEnables,
  input  logic             wakeIntEn,
  input  logic             errIntEn,
  input  logic             clrWrite,
  input  logic [7:0]       clrData,
  output logic [7:0]       rdData,
  output logic             statusIrq
);

  modeStrobes_t strb;

  canModeCtrl #(.SYNC_BITS(SYNC_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .sleepReq(sleepReq),
    .rxBit(rxBit), .bitStrobe(bitStrobe), .strb(strb)
  );

  canStatusPath #(.ERR_W(ERR_W)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb), .sofSeen(sofSeen),
    .rxBusy(rxBusy), .txBusy(txBusy), .errFlags(errFlags),
    .errEnables(errEnables), .wakeIntEn(wakeIntEn), .errIntEn(errIntEn),
    .clrWrite(clrWrite), .clrData(clrData), .statusReg(rdData),
    .statusIrq(statusIrq)
  );

  // R2: reserved bits read 0
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:6] == 2'b00)
    else $error("reserved bits set");

endmodule

// File: tb/test_canModeStatus.sv
`timescale 1ns/1ps
module test_canModeStatus;

  localparam int SYNC = 11;
  localparam int EW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initReq = 1'b0, sleepReq = 1'b1, rxBit = 1'b1, bitStrobe = 1'b0;
  logic sofSeen = 1'b0, rxBusy = 1'b0, txBusy = 1'b0;
  logic [EW-1:0] errFlags = '0, errEnables = '0;
  logic wakeIntEn = 1'b0, errIntEn = 1'b0, clrWrite = 1'b0;
  logic [7:0] clrData = 8'h00;
  logic [7:0] rdData;
  logic statusIrq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  canModeStatus #(.SYNC_BITS(SYNC), .ERR_W(EW)) i_canModeStatus (
    .clk(clk), .rstN(rstN), .initReq(initReq), .sleepReq(sleepReq),
    .rxBit(rxBit), .bitStrobe(bitStrobe), .sofSeen(sofSeen),
    .rxBusy(rxBusy), .txBusy(txBusy), .errFlags(errFlags),
    .errEnables(errEnables), .wakeIntEn(wakeIntEn), .errIntEn(errIntEn),
    .clrWrite(clrWrite), .clrData(clrData), .rdData(rdData),
    .statusIrq(statusIrq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Advance one edge, sample 1 ns later, drop single-cycle pulses
  task automatic step();
    @(posedge clk);
    #1;
    sofSeen = 1'b0;
    clrWrite = 1'b0;
    clrData = 8'h00;
    bitStrobe = 1'b0;
  endtask

  task automatic strobeBit(input logic b);
    rxBit = b;
    bitStrobe = 1'b1;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", rdData, 8'h02);
    chk("R1 reset irq", {7'b0, statusIrq}, 8'h00);
    rstN = 1'b1;
    step();
    chk("R5 sleep held", rdData, 8'h02);

    sofSeen = 1'b1;
    step();
    chk("R6 wake in sleep", rdData, 8'h0A);
    chk("R10 irq masked", {7'b0, statusIrq}, 8'h00);
    wakeIntEn = 1'b1;
    step();
    chk("R10 irq wake", {7'b0, statusIrq}, 8'h01);

    clrWrite = 1'b1; clrData = 8'hF7;
    step();
    chk("R8 zero bit no effect", rdData, 8'h0A);
    clrWrite = 1'b1; clrData = 8'h08; sofSeen = 1'b1;
    step();
    chk("R9 wake set wins", rdData, 8'h0A);
    clrWrite = 1'b1; clrData = 8'h08;
    step();
    chk("R8 wake cleared", rdData, 8'h02);
    chk("R10 irq drops", {7'b0, statusIrq}, 8'h00);

    initReq = 1'b1;
    step();
    chk("R3 init over sleep", rdData, 8'h01);
    strobeBit(1'b1);
    chk("R4 no count while requested", rdData, 8'h01);

    // R4 sweep: runs of every length below the limit, then a full run
    initReq = 1'b0; sleepReq = 1'b0;
    step();
    chk("R4 held after release", rdData, 8'h01);
    for (int run = 1; run < SYNC; run++) begin
      for (int i = 0; i < run; i++) begin
        strobeBit(1'b1);
        rxBit = 1'b0;
        step();
        chk("R4 partial run", rdData, 8'h01);
      end
      strobeBit(1'b0);
      chk("R4 dominant restart", rdData, 8'h01);
    end
    for (int i = 1; i <= SYNC; i++) begin
      strobeBit(1'b1);
      chk("R4 full run", rdData, (i < SYNC) ? 8'h01 : 8'h00);
      if (i == SYNC - 1) begin
        rxBit = 1'b0;
        step();
        chk("R4 non-strobe dominant", rdData, 8'h01);
      end
    end

    sofSeen = 1'b1;
    step();
    chk("R6 sof ignored in normal", rdData, 8'h00);

    for (int c = 0; c < 4; c++) begin
      rxBusy = c[1]; txBusy = c[0];
      step();
      chk("R11 activity", rdData, 8'(c << 4));
    end
    rxBusy = 1'b0; txBusy = 1'b0;
    step();

    // R7 sweep over every error pattern and enable mask
    errIntEn = 1'b1;
    for (int f = 0; f < (1 << EW); f++) begin
      for (int e = 0; e < (1 << EW); e++) begin
        errFlags = '0; clrWrite = 1'b1; clrData = 8'h04;
        step();
        errFlags = EW'(f); errEnables = EW'(e);
        step();
        chk("R7 error edge", rdData, ((f & e) != 0) ? 8'h04 : 8'h00);
        chk("R10 irq error", {7'b0, statusIrq}, ((f & e) != 0) ? 8'h01 : 8'h00);
      end
    end
    errFlags = '0; clrWrite = 1'b1; clrData = 8'h04;
    step();
    errFlags = '1; errEnables = '1;
    step();
    clrWrite = 1'b1; clrData = 8'h04;
    step();
    chk("R7 level does not reset", rdData, 8'h00);
    errFlags = '0;
    step();
    errFlags = 3'b010; clrWrite = 1'b1; clrData = 8'h04;
    step();
    chk("R9 error set wins", rdData, 8'h04);
    clrWrite = 1'b1; clrData = 8'h04;
    step();
    chk("R8 error cleared", rdData, 8'h00);
    errFlags = '0;

    rxBusy = 1'b1; initReq = 1'b1;
    step();
    step();
    chk("R3 normal to init", rdData, 8'h01);
    chk("R11 no activity in init", {2'b0, rdData[5:0]} & 8'h30, 8'h00);
    rxBusy = 1'b0;
    initReq = 1'b0; sleepReq = 1'b1;
    step();
    chk("R5 init to sleep", rdData, 8'h02);
    sleepReq = 1'b0;
    step();
    chk("R5 sleep exit", rdData, 8'h00);
    rxBusy = 1'b1;
    step();
    chk("R11 receiver active", rdData, 8'h20);
    rxBusy = 1'b0;
    step();
    sleepReq = 1'b1;
    step();
    chk("R5 normal to sleep", rdData, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule